// File: doc/BRIEF.md
# Compact 16-bit Varint Encoder

This block turns a 16-bit unsigned number into a short byte stream of one to three bytes. Each byte carries seven bits of the number in its low bits, least-significant group first. Its top bit is a continuation flag: it is set when another byte follows and clear on the final byte. Small numbers (below 128) cost a single byte, so the encoder suits length prefixes and counts that are usually small.

Length is capped at three bytes. The third byte only ever holds value bits [15:14] in its two low bits. Its upper six bits, including the flag position, are always zero.

The input side accepts one value per valid/ready handshake. The output side presents one byte per cycle with valid/ready and a last marker, and it holds a byte steady under backpressure until it is taken. Only one value is held at a time. A new value is not accepted until the final byte of the current one has been consumed.

Top module: `varint16_enc`

## Requirements
- R1: A value of 0x7F or less is sent as exactly one byte equal to the value, with bit 7 clear and `out_last` high (0x0000 gives 0x00, 0x007F gives 0x7F).
- R2: A value from 0x80 to 0x3FFF is sent as two bytes: {1, v[6:0]} then {0, v[13:7]} (0x0080 gives 0x80 0x01, 0x3FFF gives 0xFF 0x7F). Every byte after the first carries a non-zero 7-bit group, so no encoding is longer than needed.
- R3: A value of 0x4000 or more is sent as three bytes: {1, v[6:0]}, {1, v[13:7]}, {000000, v[15:14]}. The upper six bits of the third byte are always zero (0x4000 gives 0x80 0x80 0x01, 0xFFFF gives 0xFF 0xFF 0x03).
- R4: Bit 7 of an output byte is 1 exactly when that byte is not the final byte of its value. `out_last` is high only on the final byte.
- R5: `in_ready` is low from the cycle after a value is accepted until the cycle after its final byte is taken. `in_ready` is high whenever the block is idle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` hold their values into the next cycle. No byte is lost or repeated.
- R7: A synchronous active-high `rst` leaves `out_valid` low and `in_ready` high in the following cycle. Any partly sent value is discarded, and the next accepted value encodes from its first byte.
- R8: Bytes leave in order of ascending bit significance, one per output handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value is present |
| in_ready | output | 1 | Encoder can take a value |
| in_value | input | 16 | Unsigned value to encode |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Sink takes the byte this cycle |
| out_byte | output | 8 | Encoded byte, flag in bit 7 |
| out_last | output | 1 | Final byte of the current value |

## Verification
The bench aims at the length boundaries 0x7F/0x80 and 0x3FFF/0x4000 and at the extremes 0x0000 and 0xFFFF. A design with an off-by-one length test would emit a stray zero byte or drop a high group at these points. Random stalls on `out_ready` expose a serializer that advances without a handshake: it would skip or duplicate bytes, or change a byte that is still waiting. A reset in the middle of a three-byte value, followed by a fresh value, catches a design whose byte index survives reset and would therefore resume at a later group.

// File: rtl/varint_pkg.sv
package varint_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_e;

    // number of byte slots needed to hold val_w bits in groups of grp_w
    function automatic int group_count(input int val_w, input int grp_w);
        return (val_w + grp_w - 1) / grp_w;
    endfunction

endpackage

// File: rtl/varint_split.sv
module varint_split #(
    parameter int VAL_W = 16,
    parameter int GRP_W = 7,
    localparam int NB   = varint_pkg::group_count(VAL_W, GRP_W),
    localparam int PADW = NB * GRP_W
) (
    input  logic [VAL_W-1:0]          value,
    output logic [NB-1:0][GRP_W-1:0]  groups
);
    logic [PADW-1:0] padded;

    assign padded = PADW'(value);

    for (genvar g = 0; g < NB; g++) begin : g_grp
        assign groups[g] = padded[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/varint_len.sv
module varint_len #(
    parameter int NB    = 3,
    parameter int GRP_W = 7,
    localparam int LEN_W = $clog2(NB + 1)
) (
    input  logic [NB-1:0][GRP_W-1:0] groups,
    output logic [LEN_W-1:0]         len
);
    always_comb begin
        len = LEN_W'(1);
        for (int g = 1; g < NB; g++) begin
            if (|groups[g]) len = LEN_W'(g + 1);
        end
    end
endmodule

// File: rtl/varint_pick.sv
module varint_pick #(
    parameter int NB    = 3,
    parameter int GRP_W = 7,
    localparam int LEN_W = $clog2(NB + 1)
) (
    input  logic [NB-1:0][GRP_W-1:0] groups,
    input  logic [LEN_W-1:0]         idx,
    input  logic [LEN_W-1:0]         len,
    output logic [GRP_W:0]           byte_o,
    output logic                     last_o
);
    logic [GRP_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int g = 0; g < NB; g++) begin
            if (idx == LEN_W'(g)) sel = groups[g];
        end
        last_o = (({1'b0, idx} + 1'b1) == {1'b0, len});
        byte_o = {~last_o, sel};
    end
endmodule

// File: rtl/varint16_enc.sv
module varint16_enc #(
    parameter int VAL_W = 16,
    parameter int GRP_W = 7,
    localparam int NB    = varint_pkg::group_count(VAL_W, GRP_W),
    localparam int LEN_W = $clog2(NB + 1),
    localparam int BYTE_W = GRP_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VAL_W-1:0]  in_value,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    import varint_pkg::*;

    typedef struct packed {
        enc_state_e       st;
        logic [VAL_W-1:0] val;
        logic [LEN_W-1:0] idx;
    } enc_reg_t;

    enc_reg_t r_d, r_q;

    logic [NB-1:0][GRP_W-1:0] groups;
    logic [LEN_W-1:0]         len;
    logic [BYTE_W-1:0]        cur_byte;
    logic                     cur_last;

    varint_split #(.VAL_W(VAL_W), .GRP_W(GRP_W)) u_split (
        .value  (r_q.val),
        .groups (groups)
    );

    varint_len #(.NB(NB), .GRP_W(GRP_W)) u_len (
        .groups (groups),
        .len    (len)
    );

    varint_pick #(.NB(NB), .GRP_W(GRP_W)) u_pick (
        .groups (groups),
        .idx    (r_q.idx),
        .len    (len),
        .byte_o (cur_byte),
        .last_o (cur_last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.st  = ST_SEND;
                    r_d.val = in_value;
                    r_d.idx = '0;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    if (cur_last) begin
                        r_d.st  = ST_IDLE;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= ST_IDLE;
            r_q.val <= '0;
            r_q.idx <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_IDLE);
    assign out_valid = (r_q.st == ST_SEND);
    assign out_byte  = cur_byte;
    assign out_last  = out_valid & cur_last;
endmodule

// File: rtl/varint16_enc_chk.sv
module varint16_enc_chk #(
    parameter int VAL_W = 16,
    parameter int GRP_W = 7,
    localparam int NB    = varint_pkg::group_count(VAL_W, GRP_W),
    localparam int LEN_W = $clog2(NB + 1),
    localparam int BYTE_W = GRP_W + 1,
    localparam int TOP_BITS = VAL_W - (NB - 1) * GRP_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [VAL_W-1:0]  in_value,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_last
);
    logic [LEN_W-1:0] sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent <= '0;
        end else if (out_valid && out_ready) begin
            sent <= out_last ? '0 : sent + 1'b1;
        end
    end

    // R6: a stalled byte stays put
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    // R5: no new value while bytes are pending
    p_busy_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R4: flag bit is the inverse of the final-byte marker
    p_flag_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_byte[BYTE_W-1] == !out_last));

    // R3: top slot is final and holds only the top value bits
    p_top_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sent == LEN_W'(NB - 1)) |-> (out_last && ((out_byte >> TOP_BITS) == '0)));

    // R2: a trailing byte never carries an empty group
    p_minimal_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && sent != '0) |-> (out_byte[GRP_W-1:0] != '0));

    // R7: idle right after reset
    p_reset_r7: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready));

    // R1: single-byte values are not extended
    p_single_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sent == '0 && !out_byte[BYTE_W-1]) |-> out_last);
endmodule

bind varint16_enc varint16_enc_chk #(.VAL_W(VAL_W), .GRP_W(GRP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_value  (in_value),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
);

// File: tb/varint16_enc_test.sv
module varint16_enc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_value;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;
    logic        out_last;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    varint16_enc uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_last  (out_last)
    );

    function automatic int exp_len(input logic [15:0] v);
        if (v < 16'h0080) return 1;
        if (v < 16'h4000) return 2;
        return 3;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] v, input int i);
        logic [6:0] g;
        if (i == 0)      g = v[6:0];
        else if (i == 1) g = v[13:7];
        else             g = {5'b0, v[15:14]};
        return {(i < exp_len(v) - 1), g};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [15:0] v);
        if (v < 16'h0080) return "R1";
        if (v < 16'h4000) return "R2";
        return "R3";
    endfunction

    // send one value, drain its bytes with stalls at the given percentage
    task automatic encode_one(input logic [15:0] v, input int stall_pct);
        int          n = 0;
        bit          done = 0;
        bit          prev_stall = 0;
        logic [7:0]  prev_byte = '0;
        logic        prev_last = 1'b0;
        int          guard = 0;
        @(negedge clk);
        check(in_ready == 1'b1, "R5", "ready when idle", int'(in_ready), 1);
        in_valid = 1'b1;
        in_value = v;
        @(negedge clk);
        in_valid = 1'b0;
        in_value = $urandom;
        while (!done && guard < 200) begin
            guard++;
            out_ready = (($urandom % 100) >= stall_pct);
            check(out_valid == 1'b1, "R6", "valid while pending", int'(out_valid), 1);
            check(in_ready == 1'b0, "R5", "ready low while busy", int'(in_ready), 0);
            if (prev_stall) begin
                check(out_byte == prev_byte && out_last == prev_last, "R6",
                      "byte held under stall", int'(out_byte), int'(prev_byte));
            end
            if (out_valid && out_ready) begin
                // R8: byte n carries group n, ascending significance
                check(out_byte == exp_byte(v, n), req_of(v), $sformatf("byte %0d of 0x%0h", n, v),
                      int'(out_byte), int'(exp_byte(v, n)));
                // R4: last marker only on the final byte
                check(out_last == (n == exp_len(v) - 1), "R4", "last marker",
                      int'(out_last), int'(n == exp_len(v) - 1));
                n++;
                if (out_last || n >= 4) done = 1;
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            prev_last  = out_last;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(n == exp_len(v), "R8", $sformatf("byte count of 0x%0h", v), n, exp_len(v));
        check(in_ready == 1'b1 && out_valid == 1'b0, "R5", "idle after last byte",
              int'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] dir [8];
        void'($urandom(32'd1357));
        rst = 1'b1;
        in_valid = 1'b0;
        in_value = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "no output after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7", "ready after reset", int'(in_ready), 1);

        dir = '{16'h0000, 16'h0001, 16'h007F, 16'h0080,
                16'h3FFF, 16'h4000, 16'hC000, 16'hFFFF};
        foreach (dir[i]) encode_one(dir[i], 0);
        foreach (dir[i]) encode_one(dir[i], 60);

        for (int k = 0; k < 300; k++) begin
            logic [15:0] v;
            case ($urandom % 3)
                0:       v = 16'($urandom % 16'h0080);
                1:       v = 16'h0080 + 16'($urandom % 16'h3F80);
                default: v = 16'h4000 + 16'($urandom % 16'hC000);
            endcase
            encode_one(v, int'($urandom % 70));
        end

        // R7: reset in the middle of a three-byte value
        @(negedge clk);
        in_valid = 1'b1;
        in_value = 16'hABCD;
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R7", "partial value dropped", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7", "ready after mid-value reset", int'(in_ready), 1);
        encode_one(16'h4321, 0);
        encode_one(16'h0055, 30);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule